// File: doc/BRIEF.md
# NAND Flash Host Interface

This block is the register-mapped front end of a NAND flash controller. A processor writes command bytes, address bytes and write data into registers; each of these writes, and each read request, becomes an entry in a small write buffer. A strobe engine drains the buffer in order and drives the flash control lines. A command raises the command-latch line and an address raises the address-latch line, each for one write-enable pulse. Strobe widths come from delay fields in a control register.

A read is a two-step exchange. Software writes any value to a read-request register, which queues one read strobe. When the byte or word has been captured, a read-ready status bit sets, and software collects the value from a separate read-data register. Interrupt status bits are cleared by writing ones to them. A mask register, with every bit masked at reset, gates them onto one interrupt line.

For bulk transfers, software first pulses the ECC restart by writing the ECC-reset register. It then writes the page-control register, and the block moves a whole page of 256 or 512 bytes through a streaming page port. Transfer data on that port belongs to an external mover, and the ECC arithmetic lives outside the block.

Top module: `nand_host_if`

## Requirements
- R1: After reset, register reads return 0 for control (offset 0x0), 0 for status (0x1) and 0 for interrupt status (0x2), and 0x7 for the interrupt mask (0x3). Both strobes are high and irq is low.
- R2: Writes to offsets 0x4 (command), 0x5 (address) and 0x6 (write data) are issued in order as one write-enable pulse each, with the low byte on DQ in 8-bit mode. The command pulse has CLE high and ALE low, the address pulse has ALE high and CLE low, and the data pulse has both low.
- R3: Control register fields are: bit 0 page size (1 = 512 bytes, 0 = 256), bit 1 bus width (1 = 16-bit), bits 5:2 read delay, bits 9:6 write delay. Write enable stays low for write delay + 1 clocks, and read enable stays low for read delay + 1 clocks. The two strobes are never low together.
- R4: The write buffer holds 4 entries. Status bit 0 reads 1 while it is full, and a push made while it is full is dropped.
- R5: A write to offset 0x7 queues exactly one read strobe, whatever value is written. DQ is not driven while read enable is low. In 8-bit mode the captured value is the low DQ byte, zero-extended; in 16-bit mode it is the full 16-bit word.
- R6: When a read strobe completes, interrupt status bit 1 (read ready) sets and the read-data register (offset 0x8) holds the captured value.
- R7: Writing to offset 0x2 clears every interrupt status bit written as 1. If a bit is set and cleared in the same cycle, the set wins.
- R8: Interrupt status bit 0 (device ready) sets while the synchronized R/B input is high. Once R/B is low, a write-one clear keeps it at 0.
- R9: irq is high exactly when some interrupt status bit is 1 and its mask bit (offset 0x3) is 0.
- R10: Writing 1 to offset 0x9 starts a whole-page read and writing 2 starts a whole-page write. Status bit 1 is high during the transfer. The transfer makes page-size/1 strobes in 8-bit mode or page-size/2 in 16-bit mode, then sets interrupt status bit 2 (page done). Queued operations are not issued while a page is active.
- R11: Writing offset 0xA pulses ecc_restart for one clock and arms the page sequencer. A page start is accepted only while armed, idle and with an empty buffer. Each accepted start disarms it, so an unarmed start is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register offset |
| bus_wdata | input | 16 | Register write data |
| bus_rdata | output | 16 | Register read data (combinational on bus_addr) |
| irq | output | 1 | Unmasked interrupt request |
| ecc_restart | output | 1 | One-clock pulse restarting the external ECC accumulators |
| pg_wdata | input | 16 | Page-write data from the external mover |
| pg_wtake | output | 1 | pg_wdata consumed this cycle |
| pg_rdata | output | 16 | Page-read data |
| pg_rvalid | output | 1 | pg_rdata valid this cycle |
| nd_ce_n | output | 1 | Chip enable, active low |
| nd_cle | output | 1 | Command latch enable |
| nd_ale | output | 1 | Address latch enable |
| nd_we_n | output | 1 | Write enable, active low |
| nd_re_n | output | 1 | Read enable, active low |
| nd_dq_out | output | 16 | DQ output value |
| nd_dq_oe | output | 1 | DQ output enable |
| nd_dq_in | input | 16 | DQ input value |
| nd_rb | input | 1 | Ready/busy line from the flash |

## Verification
A read-ready event and a software clear of that same status bit can land on the same clock edge. The bench provokes this with the read delay at zero: it queues a read request, waits exactly one idle cycle, then writes a clear of bit 1. That clear lands on the edge where the strobe engine captures the data. The bench then reads the status register and expects bit 1 still set, because the set wins. A later clear on its own must bring the bit back to zero.

// File: rtl/nfc_pkg.sv
package nfc_pkg;
   localparam int NFC_DQ_W = 16;

   typedef enum logic [1:0] {OP_CMD, OP_ADDR, OP_DATA, OP_READ} op_kind_e;
   typedef enum logic [1:0] {S_IDLE, S_WLOW, S_RLOW, S_REC} eng_st_e;

   localparam logic [3:0] A_CTRL  = 4'h0;
   localparam logic [3:0] A_STAT  = 4'h1;
   localparam logic [3:0] A_ISTAT = 4'h2;
   localparam logic [3:0] A_IMASK = 4'h3;
   localparam logic [3:0] A_CMD   = 4'h4;
   localparam logic [3:0] A_ADDR  = 4'h5;
   localparam logic [3:0] A_DWR   = 4'h6;
   localparam logic [3:0] A_RDREQ = 4'h7;
   localparam logic [3:0] A_RDATA = 4'h8;
   localparam logic [3:0] A_PGCTL = 4'h9;
   localparam logic [3:0] A_ECCRS = 4'hA;
endpackage

// File: rtl/nfc_wbuf.sv
module nfc_wbuf #(
   parameter int DEPTH = 4,
   parameter int W     = 18
)(
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic [W-1:0] din,
   input  logic         pop,
   output logic [W-1:0] dout,
   output logic         full,
   output logic         empty
);
   localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CW = $clog2(DEPTH + 1);

   logic [CW-1:0] cnt;
   logic          do_push, do_pop;

   assign full    = (cnt == CW'(DEPTH));
   assign empty   = (cnt == '0);
   assign do_push = push & ~full;
   assign do_pop  = pop & ~empty;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   cnt <= '0;
      else if (do_push && !do_pop)  cnt <= cnt + 1'b1;
      else if (do_pop && !do_push)  cnt <= cnt - 1'b1;
   end

   generate
      if (DEPTH == 1) begin : g_single
         logic [W-1:0] slot;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       slot <= '0;
            else if (do_push) slot <= din;
         end
         assign dout = slot;
      end else begin : g_ring
         logic [W-1:0]  mem [DEPTH];
         logic [PW-1:0] wp, rp;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               wp <= '0;
               rp <= '0;
            end else begin
               if (do_push) wp <= (wp == PW'(DEPTH-1)) ? '0 : wp + 1'b1;
               if (do_pop)  rp <= (rp == PW'(DEPTH-1)) ? '0 : rp + 1'b1;
            end
         end
         always_ff @(posedge clk) begin
            if (do_push) mem[wp] <= din;
         end
         assign dout = mem[rp];
      end
   endgenerate
endmodule

// File: rtl/nfc_strobe.sv
module nfc_strobe import nfc_pkg::*; #(
   parameter int DLY_W = 4
)(
   input  logic                clk,
   input  logic                rst_n,
   input  logic                c_wide,
   input  logic                c_p512,
   input  logic [DLY_W-1:0]    c_rdly,
   input  logic [DLY_W-1:0]    c_wdly,
   input  logic                q_valid,
   input  op_kind_e            q_kind,
   input  logic [NFC_DQ_W-1:0] q_val,
   output logic                q_pop,
   input  logic                pg_start,
   input  logic                pg_dir_wr,
   input  logic [NFC_DQ_W-1:0] pg_wdata,
   output logic                pg_wtake,
   output logic [NFC_DQ_W-1:0] pg_rdata,
   output logic                pg_rvalid,
   output logic                pg_busy,
   output logic                pg_done,
   output logic                rd_done,
   output logic [NFC_DQ_W-1:0] rd_word,
   output logic                eng_idle,
   output logic                nd_ce_n,
   output logic                nd_cle,
   output logic                nd_ale,
   output logic                nd_we_n,
   output logic                nd_re_n,
   output logic [NFC_DQ_W-1:0] nd_dq_out,
   output logic                nd_dq_oe,
   input  logic [NFC_DQ_W-1:0] nd_dq_in
);
   localparam int BC_W = 10;

   eng_st_e             st;
   logic [DLY_W-1:0]    cnt;
   op_kind_e            kind;
   logic [NFC_DQ_W-1:0] val;
   logic                pg_act, pg_wr, is_pg;
   logic [BC_W-1:0]     bcnt;

   logic [BC_W-1:0] psize, step;
   logic            pg_end, pg_go, rd_fire;

   assign psize   = c_p512 ? BC_W'(512) : BC_W'(256);
   assign step    = c_wide ? BC_W'(2) : BC_W'(1);
   assign pg_end  = pg_act && (bcnt == psize);
   assign pg_go   = pg_act && (bcnt != psize);
   assign rd_fire = (st == S_RLOW) && (cnt == c_rdly);

   assign eng_idle  = (st == S_IDLE) && !pg_act;
   assign q_pop     = eng_idle && !pg_start && q_valid;
   assign pg_wtake  = (st == S_IDLE) && pg_go && pg_wr;
   assign pg_done   = (st == S_IDLE) && pg_end;
   assign pg_busy   = pg_act;
   assign rd_word   = c_wide ? nd_dq_in : {8'h00, nd_dq_in[7:0]};
   assign rd_done   = rd_fire && !is_pg;
   assign pg_rvalid = rd_fire && is_pg;
   assign pg_rdata  = rd_word;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= S_IDLE;
         cnt    <= '0;
         kind   <= OP_CMD;
         val    <= '0;
         pg_act <= 1'b0;
         pg_wr  <= 1'b0;
         is_pg  <= 1'b0;
         bcnt   <= '0;
      end else begin
         case (st)
            S_IDLE: begin
               cnt <= '0;
               if (pg_start && !pg_act) begin
                  pg_act <= 1'b1;
                  pg_wr  <= pg_dir_wr;
                  bcnt   <= '0;
               end else if (pg_end) begin
                  pg_act <= 1'b0;
               end else if (pg_go) begin
                  bcnt  <= bcnt + step;
                  is_pg <= 1'b1;
                  val   <= pg_wdata;
                  kind  <= pg_wr ? OP_DATA : OP_READ;
                  st    <= pg_wr ? S_WLOW : S_RLOW;
               end else if (q_valid) begin
                  is_pg <= 1'b0;
                  val   <= q_val;
                  kind  <= q_kind;
                  st    <= (q_kind == OP_READ) ? S_RLOW : S_WLOW;
               end
            end
            S_WLOW: begin
               if (cnt == c_wdly) st <= S_REC;
               else               cnt <= cnt + 1'b1;
            end
            S_RLOW: begin
               if (rd_fire) st <= S_REC;
               else         cnt <= cnt + 1'b1;
            end
            default: st <= S_IDLE;
         endcase
      end
   end

   assign nd_we_n   = (st != S_WLOW);
   assign nd_re_n   = (st != S_RLOW);
   assign nd_cle    = (st == S_WLOW) && (kind == OP_CMD);
   assign nd_ale    = (st == S_WLOW) && (kind == OP_ADDR);
   assign nd_dq_oe  = (st == S_WLOW);
   assign nd_dq_out = c_wide ? val : {8'h00, val[7:0]};
   assign nd_ce_n   = (st == S_IDLE) && !pg_act;
endmodule

// File: rtl/nand_host_if.sv
module nand_host_if import nfc_pkg::*; #(
   parameter int WB_DEPTH = 4,
   parameter int DLY_W    = 4,
   parameter int RB_SYNC  = 2
)(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        bus_wr,
   input  logic [3:0]  bus_addr,
   input  logic [15:0] bus_wdata,
   output logic [15:0] bus_rdata,
   output logic        irq,
   output logic        ecc_restart,
   input  logic [15:0] pg_wdata,
   output logic        pg_wtake,
   output logic [15:0] pg_rdata,
   output logic        pg_rvalid,
   output logic        nd_ce_n,
   output logic        nd_cle,
   output logic        nd_ale,
   output logic        nd_we_n,
   output logic        nd_re_n,
   output logic [15:0] nd_dq_out,
   output logic        nd_dq_oe,
   input  logic [15:0] nd_dq_in,
   input  logic        nd_rb
);
   localparam int RD_LSB = 2;
   localparam int WD_LSB = RD_LSB + DLY_W;
   localparam int ENT_W  = 2 + NFC_DQ_W;
   localparam int IS_W   = 3;

   generate
      if (WB_DEPTH < 1 || DLY_W < 1 || WD_LSB + DLY_W > 16 || RB_SYNC < 1) begin : g_bad_param
         $error("nand_host_if: parameter out of range");
      end
   endgenerate

   logic             c_p512, c_wide;
   logic [DLY_W-1:0] c_rdly, c_wdly;
   logic [IS_W-1:0]  istat, imask, ist_set, ist_clr;
   logic             armed;
   logic [15:0]      rd_data;
   logic [RB_SYNC-1:0] rb_q;

   logic             wb_push, wb_pop, wb_full, wb_empty;
   logic [ENT_W-1:0] wb_din, wb_dout;
   op_kind_e         push_kind;

   logic             pg_start, pg_busy, pg_done, rd_done, eng_idle;
   logic [15:0]      rd_word;

   // register write decode
   always_comb begin
      wb_push   = 1'b0;
      push_kind = OP_CMD;
      if (bus_wr) begin
         case (bus_addr)
            A_CMD:   begin wb_push = 1'b1; push_kind = OP_CMD;  end
            A_ADDR:  begin wb_push = 1'b1; push_kind = OP_ADDR; end
            A_DWR:   begin wb_push = 1'b1; push_kind = OP_DATA; end
            A_RDREQ: begin wb_push = 1'b1; push_kind = OP_READ; end
            default: ;
         endcase
      end
   end

   assign wb_din   = {push_kind, bus_wdata};
   assign pg_start = bus_wr && (bus_addr == A_PGCTL) &&
                     ((bus_wdata == 16'd1) || (bus_wdata == 16'd2)) &&
                     armed && eng_idle && wb_empty;
   assign ist_clr  = (bus_wr && bus_addr == A_ISTAT) ? bus_wdata[IS_W-1:0] : '0;
   assign ist_set  = {pg_done, rd_done, rb_q[RB_SYNC-1]};

   nfc_wbuf #(.DEPTH(WB_DEPTH), .W(ENT_W)) u_wbuf (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (wb_push),
      .din   (wb_din),
      .pop   (wb_pop),
      .dout  (wb_dout),
      .full  (wb_full),
      .empty (wb_empty)
   );

   nfc_strobe #(.DLY_W(DLY_W)) u_eng (
      .clk       (clk),
      .rst_n     (rst_n),
      .c_wide    (c_wide),
      .c_p512    (c_p512),
      .c_rdly    (c_rdly),
      .c_wdly    (c_wdly),
      .q_valid   (!wb_empty),
      .q_kind    (op_kind_e'(wb_dout[ENT_W-1 -: 2])),
      .q_val     (wb_dout[NFC_DQ_W-1:0]),
      .q_pop     (wb_pop),
      .pg_start  (pg_start),
      .pg_dir_wr (bus_wdata[1]),
      .pg_wdata  (pg_wdata),
      .pg_wtake  (pg_wtake),
      .pg_rdata  (pg_rdata),
      .pg_rvalid (pg_rvalid),
      .pg_busy   (pg_busy),
      .pg_done   (pg_done),
      .rd_done   (rd_done),
      .rd_word   (rd_word),
      .eng_idle  (eng_idle),
      .nd_ce_n   (nd_ce_n),
      .nd_cle    (nd_cle),
      .nd_ale    (nd_ale),
      .nd_we_n   (nd_we_n),
      .nd_re_n   (nd_re_n),
      .nd_dq_out (nd_dq_out),
      .nd_dq_oe  (nd_dq_oe),
      .nd_dq_in  (nd_dq_in)
   );

   // ready/busy synchronizer
   generate
      for (genvar i = 0; i < RB_SYNC; i++) begin : g_rb
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      rb_q[i] <= 1'b0;
            else if (i == 0) rb_q[i] <= nd_rb;
            else             rb_q[i] <= rb_q[(i == 0) ? 0 : i-1];
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         c_p512      <= 1'b0;
         c_wide      <= 1'b0;
         c_rdly      <= '0;
         c_wdly      <= '0;
         istat       <= '0;
         imask       <= '1;
         armed       <= 1'b0;
         rd_data     <= '0;
         ecc_restart <= 1'b0;
      end else begin
         istat       <= (istat & ~ist_clr) | ist_set;
         ecc_restart <= bus_wr && (bus_addr == A_ECCRS);
         if (rd_done) rd_data <= rd_word;
         if (pg_start)                            armed <= 1'b0;
         else if (bus_wr && bus_addr == A_ECCRS)  armed <= 1'b1;
         if (bus_wr && bus_addr == A_CTRL) begin
            c_p512 <= bus_wdata[0];
            c_wide <= bus_wdata[1];
            c_rdly <= bus_wdata[RD_LSB +: DLY_W];
            c_wdly <= bus_wdata[WD_LSB +: DLY_W];
         end
         if (bus_wr && bus_addr == A_IMASK) imask <= bus_wdata[IS_W-1:0];
      end
   end

   always_comb begin
      bus_rdata = '0;
      case (bus_addr)
         A_CTRL: begin
            bus_rdata[0]                = c_p512;
            bus_rdata[1]                = c_wide;
            bus_rdata[RD_LSB +: DLY_W]  = c_rdly;
            bus_rdata[WD_LSB +: DLY_W]  = c_wdly;
         end
         A_STAT:  bus_rdata[1:0]      = {pg_busy, wb_full};
         A_ISTAT: bus_rdata[IS_W-1:0] = istat;
         A_IMASK: bus_rdata[IS_W-1:0] = imask;
         A_RDATA: bus_rdata           = rd_data;
         default: bus_rdata           = '0;
      endcase
   end

   assign irq = |(istat & ~imask);
endmodule

// File: rtl/nand_host_if_chk.sv
module nand_host_if_chk #(
   parameter int DLY_W = 4
)(
   input logic             clk,
   input logic             rst_n,
   input logic             nd_we_n,
   input logic             nd_re_n,
   input logic             nd_cle,
   input logic             nd_ale,
   input logic             nd_dq_oe,
   input logic [2:0]       istat,
   input logic [2:0]       ist_clr,
   input logic             rd_done,
   input logic             wb_full,
   input logic             wb_pop,
   input logic             pg_busy,
   input logic [DLY_W-1:0] c_wdly
);
   logic [7:0] we_low;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        we_low <= '0;
      else if (!nd_we_n) we_low <= we_low + 1'b1;
      else               we_low <= '0;
   end

   AST_STROBE_EXCL:  assert property (@(posedge clk) disable iff (!rst_n) !(!nd_we_n && !nd_re_n)); // R3
   AST_WE_WIDTH:     assert property (@(posedge clk) disable iff (!rst_n) !nd_we_n |-> (we_low <= 8'(c_wdly))); // R3
   AST_LATCH_EXCL:   assert property (@(posedge clk) disable iff (!rst_n) !(nd_cle && nd_ale)); // R2
   AST_CLE_IN_WE:    assert property (@(posedge clk) disable iff (!rst_n) (nd_cle || nd_ale) |-> !nd_we_n); // R2
   AST_NO_DRIVE_RD:  assert property (@(posedge clk) disable iff (!rst_n) !nd_re_n |-> !nd_dq_oe); // R5
   AST_FULL_HOLD:    assert property (@(posedge clk) disable iff (!rst_n) (wb_full && !wb_pop) |=> wb_full); // R4
   AST_SET_WINS:     assert property (@(posedge clk) disable iff (!rst_n) rd_done |=> istat[1]); // R7
   AST_RDY_STICKY:   assert property (@(posedge clk) disable iff (!rst_n) (istat[1] && !ist_clr[1]) |=> istat[1]); // R6
   AST_PAGE_NO_POP:  assert property (@(posedge clk) disable iff (!rst_n) pg_busy |-> !wb_pop); // R10
endmodule

bind nand_host_if nand_host_if_chk #(.DLY_W(DLY_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .nd_we_n  (nd_we_n),
   .nd_re_n  (nd_re_n),
   .nd_cle   (nd_cle),
   .nd_ale   (nd_ale),
   .nd_dq_oe (nd_dq_oe),
   .istat    (istat),
   .ist_clr  (ist_clr),
   .rd_done  (rd_done),
   .wb_full  (wb_full),
   .wb_pop   (wb_pop),
   .pg_busy  (pg_busy),
   .c_wdly   (c_wdly)
);

// File: tb/sim_nand_host_if.sv
`timescale 1ns/1ps
module sim_nand_host_if;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic [3:0]  bus_addr = '0;
   logic [15:0] bus_wdata = '0;
   logic [15:0] bus_rdata;
   logic        irq, ecc_restart, pg_wtake, pg_rvalid;
   logic [15:0] pg_wdata = 16'h00A5;
   logic [15:0] pg_rdata;
   logic        nd_ce_n, nd_cle, nd_ale, nd_we_n, nd_re_n, nd_dq_oe;
   logic [15:0] nd_dq_out;
   logic [15:0] nd_dq_in = 16'hBEEF;
   logic        nd_rb = 1'b0;

   int checks = 0;
   int fails = 0;
   bit finished = 0;

   always #5 clk = ~clk;

   nand_host_if u0 (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq),
      .ecc_restart(ecc_restart), .pg_wdata(pg_wdata), .pg_wtake(pg_wtake),
      .pg_rdata(pg_rdata), .pg_rvalid(pg_rvalid), .nd_ce_n(nd_ce_n),
      .nd_cle(nd_cle), .nd_ale(nd_ale), .nd_we_n(nd_we_n), .nd_re_n(nd_re_n),
      .nd_dq_out(nd_dq_out), .nd_dq_oe(nd_dq_oe), .nd_dq_in(nd_dq_in),
      .nd_rb(nd_rb)
   );

   // pin monitor, sampled between edges
   int we_falls = 0, we_run = 0, we_last = 0;
   int re_run = 0, re_last = 0, oe_in_rd = 0;
   int takes = 0, rvals = 0, eccs = 0;
   logic mcle = 0, male = 0;
   logic [15:0] mdq = '0;

   always @(negedge clk) begin
      if (!nd_we_n) begin
         we_run++;
         if (we_run == 1) we_falls++;
         mcle = nd_cle; male = nd_ale; mdq = nd_dq_out;
      end else if (we_run != 0) begin
         we_last = we_run; we_run = 0;
      end
      if (!nd_re_n) begin
         re_run++;
         if (nd_dq_oe) oe_in_rd++;
      end else if (re_run != 0) begin
         re_last = re_run; re_run = 0;
      end
      if (pg_wtake)    takes++;
      if (pg_rvalid)   rvals++;
      if (ecc_restart) eccs++;
   end

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [15:0] d);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [15:0] d);
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   function automatic logic [15:0] ctl(input bit p512, input bit wide,
                                        input int rdly, input int wdly);
      return 16'(p512) | (16'(wide) << 1) | (16'(rdly) << 2) | (16'(wdly) << 6);
   endfunction

   task automatic t_reset();
      logic [15:0] v;
      rd(4'h0, v); chk("R1 ctrl", v, 0);
      rd(4'h1, v); chk("R1 status", v, 0);
      rd(4'h2, v); chk("R1 istat", v, 0);
      rd(4'h3, v); chk("R1 imask", v, 7);
      chk("R1 strobes", {nd_we_n, nd_re_n}, 3);
      chk("R9 irq at reset", irq, 0);
   endtask

   task automatic t_write_ops();
      wr(4'h0, ctl(0, 0, 0, 2));
      wr(4'h4, 16'h1190); idle(10);
      chk("R3 we width", we_last, 3);
      chk("R2 cmd latch", {mcle, male}, 2);
      chk("R2 cmd dq", mdq, 16'h0090);
      wr(4'h5, 16'h005A); idle(10);
      chk("R2 addr latch", {mcle, male}, 1);
      chk("R2 addr dq", mdq, 16'h005A);
      wr(4'h6, 16'h1234); idle(10);
      chk("R2 data latch", {mcle, male}, 0);
      chk("R2 data dq low byte", mdq, 16'h0034);
   endtask

   task automatic t_reads();
      logic [15:0] v;
      wr(4'h0, ctl(0, 0, 3, 0));
      wr(4'h7, 16'hFFFF); idle(15);
      rd(4'h2, v); chk("R6 rd ready", v[1], 1);
      rd(4'h8, v); chk("R5 byte read", v, 16'h00EF);
      chk("R3 re width", re_last, 4);
      chk("R5 dq not driven", oe_in_rd, 0);
      wr(4'h2, 16'h0002);
      rd(4'h2, v); chk("R7 w1c", v[1], 0);
      wr(4'h0, ctl(0, 1, 1, 0));
      nd_dq_in = 16'hC3A7;
      wr(4'h7, 16'h0000); idle(10);
      rd(4'h8, v); chk("R5 word read", v, 16'hC3A7);
      wr(4'h2, 16'h0002);
   endtask

   task automatic t_full();
      logic [15:0] v;
      int base;
      wr(4'h0, ctl(0, 0, 0, 15));
      base = we_falls;
      for (int i = 0; i < 6; i++) wr(4'h6, 16'(i));
      rd(4'h1, v); chk("R4 full flag", v[0], 1);
      idle(200);
      chk("R4 dropped push", we_falls - base, 5);
      rd(4'h1, v); chk("R4 drained", v[0], 0);
   endtask

   task automatic t_collide();
      logic [15:0] v;
      wr(4'h0, ctl(0, 0, 0, 0));
      wr(4'h2, 16'h0007);
      wr(4'h7, 16'h0000);   // request lands at edge E0
      idle(1);              // E1: engine pops
      wr(4'h2, 16'h0002);   // clear lands at E2, same edge as capture
      rd(4'h2, v); chk("R7 set wins", v[1], 1);
      wr(4'h2, 16'h0002);
      rd(4'h2, v); chk("R7 later clear", v[1], 0);
   endtask

   task automatic t_ready();
      logic [15:0] v;
      nd_rb = 1'b1; idle(5);
      rd(4'h2, v); chk("R8 ready set", v[0], 1);
      chk("R9 masked", irq, 0);
      wr(4'h3, 16'h0006);
      chk("R9 unmasked", irq, 1);
      nd_rb = 1'b0; idle(4);
      wr(4'h2, 16'h0001);
      rd(4'h2, v); chk("R8 ready cleared", v[0], 0);
      chk("R9 irq drop", irq, 0);
      wr(4'h3, 16'h0007);
   endtask

   task automatic t_pages();
      logic [15:0] v;
      int t0, r0, e0;
      wr(4'h0, ctl(0, 0, 0, 0));
      wr(4'h2, 16'h0007);
      t0 = takes;
      wr(4'h9, 16'h0002); idle(20);
      rd(4'h1, v); chk("R11 unarmed ignored", v[1], 0);
      chk("R11 no takes", takes - t0, 0);
      e0 = eccs;
      wr(4'hA, 16'h0000); idle(2);
      chk("R11 ecc pulse", eccs - e0, 1);
      wr(4'h9, 16'h0002);
      rd(4'h1, v); chk("R10 busy", v[1], 1);
      idle(1000);
      chk("R10 write takes", takes - t0, 256);
      chk("R10 write dq", mdq, 16'h00A5);
      rd(4'h2, v); chk("R10 page done", v[2], 1);
      rd(4'h1, v); chk("R10 not busy", v[1], 0);
      wr(4'h2, 16'h0007);
      wr(4'h0, ctl(1, 1, 0, 0));
      wr(4'hA, 16'h0000);
      r0 = rvals;
      wr(4'h9, 16'h0001); idle(1000);
      chk("R10 read words", rvals - r0, 256);
      rd(4'h2, v); chk("R10 read done", v[2], 1);
      wr(4'h2, 16'h0007);
      r0 = rvals;
      wr(4'h9, 16'h0001); idle(20);
      chk("R11 rearm needed", rvals - r0, 0);
   endtask

   initial begin
      idle(3);
      rst_n = 1'b1;
      idle(2);
      t_reset();
      t_write_ops();
      t_reads();
      t_full();
      t_collide();
      t_ready();
      t_pages();
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         checks++;
         fails++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end
endmodule